// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This datapath block sits between the register file and a 32-bit big-endian data memory port. It forms the effective address of an access from a base register and a signed 16-bit displacement. For stores it places the source register's low byte, halfword or word on the memory data lanes and raises byte enables only for the lanes being written. For loads it picks the addressed byte or halfword out of the returned memory word and extends it. It also handles the two unaligned word loads that merge shifted memory bytes into the old destination value. Every loaded value goes into a 64-bit register in canonical form: the upper 32 bits copy bit 31.

The address, write data, byte enables and misalignment flag are combinational from the inputs. The load result is captured on the clock edge at which the memory data is presented with its valid strobe, so it appears one cycle later. A mode input selects 64-bit or 32-bit addressing.

Top module: `lsu_align_top`

## Requirements
- R1: With `wide_i` = 1, `addr_o` equals `base_i` plus `offset_i` sign-extended to 64 bits, wrapping modulo 2^64.
- R2: With `wide_i` = 0, `addr_o` is the low 32 bits of that same sum, sign-extended from bit 31 to 64 bits.
- R3: Memory is big-endian. Byte offset k = `addr_o[1:0]` maps to data bits 31-8k down to 24-8k. Op code 0 loads the addressed byte sign-extended. Op code 1 loads it zero-extended.
- R4: Op code 2 loads the halfword at offset k (k = 0 or 2, bits 31-8k down to 16-8k) sign-extended. Op code 3 loads the same halfword zero-extended.
- R5: Op code 4 loads the whole memory word sign-extended to 64 bits.
- R6: Op code 5 (word-left load) at offset k places memory bytes k..3 in result bytes 3..k (byte 3 = bits 31:24) and keeps the low k bytes of the old `rt_i`. The 32-bit merge is then sign-extended.
- R7: Op code 6 (word-right load) at offset k places memory bytes 0..k in the low k+1 result bytes and keeps the upper 3-k bytes of the old `rt_i` low word. The 32-bit merge is then sign-extended.
- R8: Op codes 8, 9 and 10 store a byte, halfword or word. `wdata_o` is `rt_i[7:0]` repeated four times, `rt_i[15:0]` repeated twice, or `rt_i[31:0]`. `be_o` bit i enables data bits 8i+7:8i. A byte store at offset k sets only bit 3-k. A halfword store sets 1100 at offset 0 and 0011 at offset 2. A word store sets 1111. Any other op code leaves `be_o` at 0.
- R9: A halfword access (op 2, 3, 9) with `addr_o[0]` set, or a word access (op 4, 10) with `addr_o[1:0]` nonzero, raises `addr_err_o`, forces `be_o` to 0 and produces no load result.
- R10: When `rvalid_i` is high at a clock edge with an aligned load (op 0 to 6), `result_o` takes the loaded value and `result_vld_o` is high for the following cycle. Otherwise `result_vld_o` is low and `result_o` holds. Op codes 7 and 11 to 15 do nothing.
- R11: In both modes, the upper 32 bits of every loaded result equal bit 31.
- R12: Synchronous active-high reset clears `result_o` and `result_vld_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Access op code |
| wide_i | input | 1 | 1 = 64-bit addressing, 0 = 32-bit addressing |
| base_i | input | 64 | Base register value |
| rt_i | input | 64 | Store source / old destination value |
| offset_i | input | 16 | Signed displacement |
| rdata_i | input | 32 | Memory read data |
| rvalid_i | input | 1 | Read data valid strobe |
| addr_o | output | 64 | Effective address |
| wdata_o | output | 32 | Store data lanes |
| be_o | output | 4 | Byte enables, bit i = bits 8i+7:8i |
| addr_err_o | output | 1 | Misaligned access flag |
| result_o | output | 64 | Registered load result |
| result_vld_o | output | 1 | Load result updated this cycle |

## Verification
Assertions check several properties on every cycle. A misaligned access never enables a lane, and a load never drives byte enables. A 32-bit-mode address is always in canonical form. An updated result always has its upper half equal to bit 31. Without an update the result holds, and an update always follows a valid strobe. Whether the chosen bytes, the extension and the left/right merges are correct can only be shown by the bench. It sweeps every op code, every byte offset and both modes over several data patterns, including displacements that cross the 32-bit boundary.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [3:0] {
    OP_LDB  = 4'd0,
    OP_LDBU = 4'd1,
    OP_LDH  = 4'd2,
    OP_LDHU = 4'd3,
    OP_LDW  = 4'd4,
    OP_LDWL = 4'd5,
    OP_LDWR = 4'd6,
    OP_STB  = 4'd8,
    OP_STH  = 4'd9,
    OP_STW  = 4'd10
  } lsu_op_e;

  function automatic logic op_is_load(input logic [3:0] op);
    return (op <= 4'd6);
  endfunction

  function automatic logic op_is_store(input logic [3:0] op);
    return (op >= 4'd8) && (op <= 4'd10);
  endfunction
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
  parameter int XLEN  = 64,
  parameter int OFF_W = 16,
  parameter int NARROW = 32,
  parameter int LW    = 2
) (
  input  logic [3:0]      op_i,
  input  logic            wide_i,
  input  logic [XLEN-1:0] base_i,
  input  logic [OFF_W-1:0] offset_i,
  output logic [XLEN-1:0] addr_o,
  output logic [LW-1:0]   lane_o,
  output logic            misalign_o
);
  import lsu_pkg::*;

  logic [XLEN-1:0] sum;
  lsu_op_e op;

  assign op  = lsu_op_e'(op_i);
  assign sum = base_i + {{(XLEN-OFF_W){offset_i[OFF_W-1]}}, offset_i};

  always_comb begin
    if (wide_i) addr_o = sum;
    else        addr_o = {{(XLEN-NARROW){sum[NARROW-1]}}, sum[NARROW-1:0]};
  end

  assign lane_o = addr_o[LW-1:0];

  always_comb begin
    case (op)
      OP_LDH, OP_LDHU, OP_STH: misalign_o = lane_o[0];
      OP_LDW, OP_STW:          misalign_o = |lane_o;
      default:                 misalign_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes #(
  parameter int BUS_W = 32,
  parameter int LANES = BUS_W / 8,
  parameter int LW    = $clog2(LANES)
) (
  input  logic [3:0]       op_i,
  input  logic [LW-1:0]    lane_i,
  input  logic             misalign_i,
  input  logic [BUS_W-1:0] rt_i,
  output logic [BUS_W-1:0] wdata_o,
  output logic [LANES-1:0] be_o
);
  import lsu_pkg::*;

  lsu_op_e op;
  logic    wr_ok;

  assign op    = lsu_op_e'(op_i);
  assign wr_ok = op_is_store(op_i) && !misalign_i;

  always_comb begin
    case (op)
      OP_STB:  wdata_o = {LANES{rt_i[7:0]}};
      OP_STH:  wdata_o = {(LANES/2){rt_i[15:0]}};
      default: wdata_o = rt_i;
    endcase
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int BOFF = LANES - 1 - i;
    logic hit;
    always_comb begin
      case (op)
        OP_STB:  hit = (lane_i == LW'(BOFF));
        OP_STH:  hit = (lane_i[LW-1:1] == (LW-1)'(BOFF >> 1));
        OP_STW:  hit = 1'b1;
        default: hit = 1'b0;
      endcase
    end
    assign be_o[i] = wr_ok && hit;
  end
endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align #(
  parameter int XLEN  = 64,
  parameter int BUS_W = 32,
  parameter int LANES = BUS_W / 8,
  parameter int LW    = $clog2(LANES)
) (
  input  logic [3:0]       op_i,
  input  logic [LW-1:0]    lane_i,
  input  logic [BUS_W-1:0] rdata_i,
  input  logic [BUS_W-1:0] rt_i,
  output logic [XLEN-1:0]  value_o
);
  import lsu_pkg::*;

  localparam int SH_W = LW + 3;

  lsu_op_e          op;
  logic [SH_W-1:0]  sh_left, sh_right, sh_half;
  logic [BUS_W-1:0] byte_w, half_w, left_w, right_w;
  logic [BUS_W-1:0] keep_l, keep_r;
  logic [7:0]       b;
  logic [15:0]      h;

  assign op       = lsu_op_e'(op_i);
  assign sh_left  = {lane_i, 3'b000};
  assign sh_right = {LW'(LANES - 1) - lane_i, 3'b000};
  assign sh_half  = {LW'(LANES - 2) - lane_i, 3'b000};

  assign byte_w = rdata_i >> sh_right;
  assign half_w = rdata_i >> sh_half;
  assign b      = byte_w[7:0];
  assign h      = half_w[15:0];

  assign keep_l  = ~({BUS_W{1'b1}} << sh_left);
  assign keep_r  = ~({BUS_W{1'b1}} >> sh_right);
  assign left_w  = (rdata_i << sh_left)  | (rt_i & keep_l);
  assign right_w = (rdata_i >> sh_right) | (rt_i & keep_r);

  always_comb begin
    case (op)
      OP_LDB:  value_o = {{(XLEN-8){b[7]}}, b};
      OP_LDBU: value_o = {{(XLEN-8){1'b0}}, b};
      OP_LDH:  value_o = {{(XLEN-16){h[15]}}, h};
      OP_LDHU: value_o = {{(XLEN-16){1'b0}}, h};
      OP_LDWL: value_o = {{(XLEN-BUS_W){left_w[BUS_W-1]}}, left_w};
      OP_LDWR: value_o = {{(XLEN-BUS_W){right_w[BUS_W-1]}}, right_w};
      default: value_o = {{(XLEN-BUS_W){rdata_i[BUS_W-1]}}, rdata_i};
    endcase
  end
endmodule

// File: rtl/lsu_align_top.sv
module lsu_align_top #(
  parameter int XLEN  = 64,
  parameter int OFF_W = 16,
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       op_i,
  input  logic             wide_i,
  input  logic [XLEN-1:0]  base_i,
  input  logic [XLEN-1:0]  rt_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic [BUS_W-1:0] rdata_i,
  input  logic             rvalid_i,
  output logic [XLEN-1:0]  addr_o,
  output logic [BUS_W-1:0] wdata_o,
  output logic [BUS_W/8-1:0] be_o,
  output logic             addr_err_o,
  output logic [XLEN-1:0]  result_o,
  output logic             result_vld_o
);
  import lsu_pkg::*;

  localparam int LANES = BUS_W / 8;
  localparam int LW    = $clog2(LANES);

  logic [LW-1:0]   lane;
  logic [XLEN-1:0] ld_value;
  logic            take;

  lsu_addr_gen #(.XLEN(XLEN), .OFF_W(OFF_W), .NARROW(BUS_W), .LW(LW)) u_addr (
    .op_i(op_i), .wide_i(wide_i), .base_i(base_i), .offset_i(offset_i),
    .addr_o(addr_o), .lane_o(lane), .misalign_o(addr_err_o)
  );

  lsu_store_lanes #(.BUS_W(BUS_W), .LANES(LANES), .LW(LW)) u_store (
    .op_i(op_i), .lane_i(lane), .misalign_i(addr_err_o),
    .rt_i(rt_i[BUS_W-1:0]), .wdata_o(wdata_o), .be_o(be_o)
  );

  lsu_load_align #(.XLEN(XLEN), .BUS_W(BUS_W), .LANES(LANES), .LW(LW)) u_load (
    .op_i(op_i), .lane_i(lane), .rdata_i(rdata_i),
    .rt_i(rt_i[BUS_W-1:0]), .value_o(ld_value)
  );

  assign take = rvalid_i && op_is_load(op_i) && !addr_err_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o     <= '0;
      result_vld_o <= 1'b0;
    end else begin
      result_vld_o <= take;
      if (take) result_o <= ld_value;
    end
  end

  // R9: a misaligned access enables no lane
  a_r9_err_no_be: assert property (@(posedge clk) disable iff (rst)
    addr_err_o |-> (be_o == '0));

  // R8: loads never write memory
  a_r8_load_no_be: assert property (@(posedge clk) disable iff (rst)
    op_is_load(op_i) |-> (be_o == '0));

  // R2: 32-bit mode addresses are canonical
  a_r2_narrow_canon: assert property (@(posedge clk) disable iff (rst)
    !wide_i |-> (addr_o[XLEN-1:BUS_W] == {(XLEN-BUS_W){addr_o[BUS_W-1]}}));

  // R11: updated results are canonical
  a_r11_canonical: assert property (@(posedge clk) disable iff (rst)
    result_vld_o |-> (result_o[XLEN-1:BUS_W] == {(XLEN-BUS_W){result_o[BUS_W-1]}}));

  // R10: an update always follows a valid strobe
  a_r10_after_strobe: assert property (@(posedge clk) disable iff (rst)
    result_vld_o |-> $past(rvalid_i));

  // R10: result holds when not updated
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !result_vld_o |-> (result_o == $past(result_o)));
endmodule

// File: tb/lsu_align_top_test.sv
`timescale 1ns/1ps
module lsu_align_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_i = '0;
  logic        wide_i = 1'b1;
  logic [63:0] base_i = '0;
  logic [63:0] rt_i = '0;
  logic [15:0] offset_i = '0;
  logic [31:0] rdata_i = '0;
  logic        rvalid_i = 1'b0;
  logic [63:0] addr_o;
  logic [31:0] wdata_o;
  logic [3:0]  be_o;
  logic        addr_err_o;
  logic [63:0] result_o;
  logic        result_vld_o;

  int checks = 0;
  int errors = 0;
  logic [63:0] exp_res = '0;

  always #2.5 clk = ~clk;

  lsu_align_top uut (
    .clk(clk), .rst(rst), .op_i(op_i), .wide_i(wide_i), .base_i(base_i),
    .rt_i(rt_i), .offset_i(offset_i), .rdata_i(rdata_i), .rvalid_i(rvalid_i),
    .addr_o(addr_o), .wdata_o(wdata_o), .be_o(be_o), .addr_err_o(addr_err_o),
    .result_o(result_o), .result_vld_o(result_vld_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] sx32(input logic [63:0] v);
    return {{32{v[31]}}, v[31:0]};
  endfunction

  function automatic logic [63:0] e_addr(input logic [63:0] b, input logic [15:0] o, input logic w);
    logic [63:0] s = b + {{48{o[15]}}, o};
    return w ? s : sx32(s);
  endfunction

  function automatic logic e_err(input int op, input int k);
    return ((op == 2 || op == 3 || op == 9) && (k % 2 == 1)) ||
           ((op == 4 || op == 10) && k != 0);
  endfunction

  function automatic logic [3:0] e_be(input int op, input int k);
    if (e_err(op, k)) return 4'b0000;
    case (op)
      8:  return 4'b1000 >> k;
      9:  return (k == 0) ? 4'b1100 : 4'b0011;
      10: return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [31:0] e_wdata(input int op, input logic [63:0] rt);
    if (op == 8) return {4{rt[7:0]}};
    if (op == 9) return {2{rt[15:0]}};
    return rt[31:0];
  endfunction

  function automatic logic [63:0] e_load(input int op, input int k, input logic [31:0] m, input logic [63:0] rt);
    logic [63:0] mm = {32'd0, m};
    logic [63:0] r32 = {32'd0, rt[31:0]};
    logic [63:0] bv = (mm >> (8 * (3 - k))) & 64'hff;
    logic [63:0] hv = (mm >> (8 * (2 - k))) & 64'hffff;
    case (op)
      0: return bv[7] ? (bv | 64'hffff_ffff_ffff_ff00) : bv;
      1: return bv;
      2: return hv[15] ? (hv | 64'hffff_ffff_ffff_0000) : hv;
      3: return hv;
      4: return sx32(mm);
      5: return sx32(((mm << (8 * k)) & 64'hffff_ffff) | (r32 & ((64'd1 << (8 * k)) - 1)));
      default: return sx32((mm >> (8 * (3 - k))) | (r32 & ~((64'd1 << (8 * (k + 1))) - 1) & 64'hffff_ffff));
    endcase
  endfunction

  function automatic string rq(input int op);
    case (op)
      0, 1: return "R3";
      2, 3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      default: return "R10";
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] bases [3];
    logic [15:0] offs  [3];
    logic [31:0] mems  [3];
    logic [63:0] rts   [3];
    bases[0] = 64'h0000_0000_7fff_fff0; offs[0] = 16'h0010;
    bases[1] = 64'h1234_5678_0000_1000; offs[1] = 16'hfff8;
    bases[2] = 64'hffff_ffff_ffff_fffc; offs[2] = 16'h0004;
    mems[0] = 32'h8192_a3f4; mems[1] = 32'h1122_3344; mems[2] = 32'h7f80_01fe;
    rts[0] = 64'hdead_beef_cafe_5a5a; rts[1] = 64'h0123_4567_0089_abcd; rts[2] = 64'hffff_ffff_8000_7f00;

    repeat (3) @(posedge clk);
    #1;
    check("R12 reset result", result_o, 64'd0);
    check("R12 reset valid", {63'd0, result_vld_o}, 64'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int p = 0; p < 3; p++) begin
      for (int w = 0; w < 2; w++) begin
        for (int op = 0; op < 16; op++) begin
          for (int k = 0; k < 4; k++) begin
            logic [63:0] ea;
            logic        upd;
            @(negedge clk);
            op_i = 4'(op); wide_i = w[0]; base_i = bases[p];
            offs[p][1:0] = 2'(k);
            offset_i = offs[p]; rt_i = rts[(p + op) % 3]; rdata_i = mems[(p + k) % 3];
            rvalid_i = 1'b1;
            #0.5;
            ea = e_addr(base_i, offset_i, wide_i);
            check(w ? "R1 address" : "R2 address", addr_o, ea);
            check("R9 error flag", {63'd0, addr_err_o}, {63'd0, e_err(op, k)});
            check("R8 byte enables", {60'd0, be_o}, {60'd0, e_be(op, k)});
            if (op >= 8 && op <= 10)
              check("R8 write data", {32'd0, wdata_o}, {32'd0, e_wdata(op, rt_i)});
            upd = (op <= 6) && !e_err(op, k);
            if (upd) exp_res = e_load(op, k, rdata_i, rt_i);
            @(posedge clk);
            #0.5;
            check(upd ? rq(op) : "R10 hold", result_o, exp_res);
            check("R10 valid", {63'd0, result_vld_o}, {63'd0, upd});
            if (upd)
              check("R11 canonical", result_o, sx32(result_o));
          end
        end
      end
    end

    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      op_i = 4'd4; wide_i = 1'b1; base_i = 64'h100; offset_i = 16'h0;
      rdata_i = 32'h5555_aaaa + 32'(k); rvalid_i = 1'b0;
      @(posedge clk);
      #0.5;
      check("R10 no strobe hold", result_o, exp_res);
      check("R10 no strobe valid", {63'd0, result_vld_o}, 64'd0);
    end

    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #0.5;
    check("R12 reset clears result", result_o, 64'd0);
    check("R12 reset clears valid", {63'd0, result_vld_o}, 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule